// File: doc/BRIEF.md
# Distributed arithmetic FIR filter

This block is a single-rate FIR filter with fixed coefficients and no multipliers. Coefficient partial sums are worked out at elaboration and held in small tables. Each table serves a group of four taps. A table is addressed by the bits that share one bit position across the samples in that group. The tables for each group are summed into a slice term. A shift-accumulator then weights the slice terms and adds them into one output sample over a few clock cycles.

Samples and coefficients are two's-complement values. Bit slices are handled least significant first, `DIGIT` slices per cycle. `DIGIT = 1` gives bit-serial operation and `DIGIT = DW` gives bit-parallel operation. The sign slice is subtracted rather than added. `PIPE = 1` adds one register stage between the slice adders and the accumulator. A sample presented with `valid_i` while the filter is idle enters the delay line and starts a computation. A sample presented while a computation is running is dropped.

Top module: `da_fir`

## Requirements
- R1: Each result `y_o` equals the exact full-precision sum over taps i of h_i times x[n-i], where x[n] is the newest accepted sample. All values are two's complement and no rounding or truncation is applied.
- R2: The table for each group of four taps returns, at address a, the sum of the coefficients whose bit in a is set. A single unit sample followed by zeros therefore yields h_0, h_1, … h_{TAPS-1} in order.
- R3: The sign slice (bit DW-1) is weighted by -2^(DW-1). A delay line full of the most negative sample gives -2^(DW-1) times the sum of all coefficients.
- R4: `valid_o` is high for exactly one cycle. It rises DW/DIGIT + PIPE clock edges after the edge that accepted the sample.
- R5: A `valid_i` that arrives while a computation is running is ignored. The delay line does not change and no extra result is produced.
- R6: `y_o` holds its value between `valid_o` pulses.
- R7: After `rst_ni` is released, `valid_o` is 0, `y_o` is 0 and the delay line holds zeros.
- R8: The bit-serial variant (DIGIT = 1, PIPE = 0) gives the same results as the digit-serial variant, with a latency of DW cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Sample strobe; taken only when idle |
| x_i | input | DW | Two's-complement input sample |
| valid_o | output | 1 | One-cycle result strobe |
| y_o | output | CW+DW+clog2(TAPS) | Two's-complement filter output |

## Verification
The assertions assume `valid_i` and `x_i` are two-state and stable around the rising edge. They do not assume that `valid_i` stays low during a computation: a sample arriving while busy is a legal case that the block must drop. The stimulus drives inputs on the falling edge. It waits a full result window after each sample, so every result can be traced to one accepted sample. It also adds a deliberate strobe in the middle of a computation to exercise the drop.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;
  localparam int GRP = 4;             // taps per lookup table
  localparam int GRP_ENTRIES = 1 << GRP;
endpackage

// File: rtl/da_rom.sv
module da_rom
  import da_fir_pkg::*;
#(
  parameter int CW = 8,
  parameter logic [GRP*CW-1:0] GCOEF = '0
) (
  input  logic [GRP-1:0]       addr_i,
  output logic signed [CW+1:0] sum_o
);
  localparam int SW = CW + 2;

  function automatic logic signed [SW-1:0] entry(input int a);
    logic signed [SW-1:0] s;
    s = '0;
    for (int i = 0; i < GRP; i++)
      if (a[i]) s = s + SW'($signed(GCOEF[i*CW +: CW]));
    return s;
  endfunction

  logic signed [SW-1:0] rom [GRP_ENTRIES];
  for (genvar a = 0; a < GRP_ENTRIES; a++) begin : g_ent
    assign rom[a] = entry(a);
  end

  assign sum_o = rom[addr_i];
endmodule

// File: rtl/da_slice.sv
module da_slice
  import da_fir_pkg::*;
#(
  parameter int NGRP = 2,
  parameter int CW   = 8,
  parameter int AW   = 12,
  parameter logic [NGRP*GRP*CW-1:0] COEFP = '0
) (
  input  logic [NGRP*GRP-1:0] bits_i,
  output logic signed [AW-1:0] a_o
);
  logic signed [CW+1:0] g_sum [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    da_rom #(.CW(CW), .GCOEF(COEFP[g*GRP*CW +: GRP*CW])) u_rom (
      .addr_i(bits_i[g*GRP +: GRP]),
      .sum_o (g_sum[g])
    );
  end

  always_comb begin
    a_o = '0;
    for (int g = 0; g < NGRP; g++) a_o = a_o + AW'(g_sum[g]);
  end
endmodule

// File: rtl/da_fir.sv
module da_fir
  import da_fir_pkg::*;
#(
  parameter int TAPS  = 8,
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int DIGIT = 2,
  parameter int PIPE  = 1,
  parameter logic [TAPS*CW-1:0] COEFS = 64'h09C44D00FD2D807F,
  localparam int OW = CW + DW + $clog2(TAPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] x_i,
  output logic          valid_o,
  output logic [OW-1:0] y_o
);
  localparam int NGRP  = (TAPS + GRP - 1) / GRP;
  localparam int TP    = NGRP * GRP;
  localparam int STEPS = DW / DIGIT;
  localparam int CNTW  = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int AW    = CW + $clog2(TAPS) + 1;
  localparam int SUMW  = AW + DIGIT + 1;
  localparam int ACW   = AW + DW + 1;
  localparam logic [TP*CW-1:0] COEFP = (TP*CW)'(COEFS);

  logic [DW-1:0]   dl_q [TAPS];
  logic [DW-1:0]   wk_q [TAPS];
  logic            busy_q;
  logic [CNTW-1:0] cnt_q;
  logic            accept;

  assign accept = valid_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < TAPS; t++) begin
        dl_q[t] <= '0;
        wk_q[t] <= '0;
      end
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      dl_q[0] <= x_i;
      wk_q[0] <= x_i;
      for (int t = 1; t < TAPS; t++) begin
        dl_q[t] <= dl_q[t-1];
        wk_q[t] <= dl_q[t-1];
      end
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      for (int t = 0; t < TAPS; t++) wk_q[t] <= wk_q[t] >> DIGIT;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNTW'(STEPS - 1)) busy_q <= 1'b0;
    end
  end

  // one slice per digit bit, LSB first
  logic [TP-1:0]        sbits [DIGIT];
  logic signed [AW-1:0] a_s   [DIGIT];

  always_comb begin
    for (int d = 0; d < DIGIT; d++) begin
      sbits[d] = '0;
      for (int t = 0; t < TAPS; t++) sbits[d][t] = wk_q[t][d];
    end
  end

  for (genvar d = 0; d < DIGIT; d++) begin : g_slice
    da_slice #(.NGRP(NGRP), .CW(CW), .AW(AW), .COEFP(COEFP)) u_slice (
      .bits_i(sbits[d]),
      .a_o   (a_s[d])
    );
  end

  logic                  last_c;
  logic signed [SUMW-1:0] dsum;
  logic signed [ACW-1:0]  term_c;

  assign last_c = (cnt_q == CNTW'(STEPS - 1));

  always_comb begin
    dsum = '0;
    for (int d = 0; d < DIGIT; d++) begin
      if (last_c && d == DIGIT - 1) dsum = dsum - (SUMW'(a_s[d]) <<< d);  // sign slice
      else                          dsum = dsum + (SUMW'(a_s[d]) <<< d);
    end
    term_c = ACW'(dsum) <<< (int'(cnt_q) * DIGIT);
  end

  // optional register between slice adders and accumulator
  logic signed [ACW-1:0] t_d;
  logic                  tv_d, tf_d, tl_d;

  if (PIPE != 0) begin : g_pipe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        t_d  <= '0;
        tv_d <= 1'b0;
        tf_d <= 1'b0;
        tl_d <= 1'b0;
      end else begin
        t_d  <= term_c;
        tv_d <= busy_q;
        tf_d <= busy_q && cnt_q == '0;
        tl_d <= busy_q && last_c;
      end
    end
  end else begin : g_nopipe
    assign t_d  = term_c;
    assign tv_d = busy_q;
    assign tf_d = busy_q && cnt_q == '0;
    assign tl_d = busy_q && last_c;
  end

  logic signed [ACW-1:0] acc_q, acc_n;
  assign acc_n = (tf_d ? ACW'(0) : acc_q) + t_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      valid_o <= 1'b0;
      y_o     <= '0;
    end else begin
      valid_o <= 1'b0;
      if (tv_d) acc_q <= acc_n;
      if (tl_d) begin
        valid_o <= 1'b1;
        y_o     <= acc_n[OW-1:0];
      end
    end
  end

  // R4
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= CNTW'(STEPS - 1));
  // R5
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && valid_i) |=> ($stable(dl_q[0]) && $stable(dl_q[TAPS-1])));
  // R6
  y_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(y_o));
endmodule

// File: tb/da_fir_bench.sv
`timescale 1ns/1ps
module da_fir_bench;
  localparam logic [63:0] CF = 64'h09C44D00FD2D807F;
  localparam int H[8] = '{127, -128, 45, -3, 0, 77, -60, 9};
  localparam int NV = 24;
  localparam int VEC[NV] = '{1, 0, 0, 0, 0, 0, 0, 0,
                             -128, -128, -128, -128, -128, -128, -128, -128,
                             127, 127, -1, -128, 127, 0, 100, -77};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_ni, valid_i;
  logic [7:0]  x_i;
  logic        va, vb;
  logic [18:0] ya, yb;

  da_fir #(.COEFS(CF)) u_da_fir (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i),
    .valid_o(va), .y_o(ya));

  da_fir #(.DIGIT(1), .PIPE(0), .COEFS(CF)) u_da_fir_serial (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i),
    .valid_o(vb), .y_o(yb));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0, n_fail = 0;
  int hist[8];
  int acc_cyc, cnt_a, cnt_b, lat_a, lat_b;
  longint got_a, got_b;

  always @(negedge clk) begin
    if (va) begin cnt_a++; got_a = longint'($signed(ya)); lat_a = cyc - acc_cyc; end
    if (vb) begin cnt_b++; got_b = longint'($signed(yb)); lat_b = cyc - acc_cyc; end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int x, input bit junk, input string req);
    longint e;
    @(negedge clk);
    x_i = x[7:0]; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    acc_cyc = cyc; cnt_a = 0; cnt_b = 0;
    if (junk) begin
      @(negedge clk); x_i = 8'h55; valid_i = 1'b1;  // while busy: dropped
      @(negedge clk); valid_i = 1'b0;
    end
    for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    e = 0;
    for (int i = 0; i < 8; i++) e += longint'(H[i]) * longint'(hist[i]);
    repeat (14) @(negedge clk);
    chk(req, got_a, e);
    chk("R8", got_b, e);
    chk(junk ? "R5" : "R4", cnt_a, 1);
    chk(junk ? "R5" : "R8", cnt_b, 1);
    chk("R4", lat_a, 5);
    chk("R8", lat_b, 8);
    chk("R6", longint'($signed(ya)), got_a);
  endtask

  bit done = 1'b0;
  initial begin
    #(100000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) hist[i] = 0;
    rst_ni = 1'b0; valid_i = 1'b0; x_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R7", va, 0);
    chk("R7", longint'(ya), 0);
    chk("R7", vb, 0);
    for (int v = 0; v < NV; v++)
      send(VEC[v], 1'b0, (v < 8) ? "R2" : (v < 16) ? "R3" : "R1");
    send(50, 1'b1, "R5");
    send(-128, 1'b1, "R5");
    send(-7, 1'b0, "R5");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule